// File: doc/BRIEF.md
# I2C Target with Software-Decided Acknowledge

This block answers as a target (slave) on a two-wire serial bus. A system clock that is much faster than the bus samples SCL and SDA. Each line passes through a synchronizer and a three-sample majority vote before the block looks for edges. The block recognises START, repeated START and STOP. It compares the 7-bit address in the first byte with its own address, takes the direction bit, and then either receives data bytes from the controller or sends bytes to it. Both lines are open-drain. The block only ever pulls a line low, and it reports that through a drive-low enable.

A small register port connects the block to the host. Through it the host sets the own address and the acknowledge mode, reads received bytes, supplies bytes to send, gives the acknowledge decision and reads sticky status flags. In automatic mode every received byte is acknowledged at once. In manual mode the block stretches SCL after the eighth bit of each received byte, until the host writes ACK or NACK. When the block sends data and the host has no byte ready, it also stretches SCL until a byte arrives.

Top module: `i2c_tgt_defer`

## Requirements
- R1: The first byte after a START carries the address in bits 7:1, most significant bit first, and the direction in bit 0 (0 = controller writes, 1 = controller reads). On a match with the own address (register 0, bits 6:0) the block pulls SDA low in the ninth clock. It then sets status bit 0 (matched), and sets status bit 1 when the direction is read.
- R2: On an address mismatch the block never pulls SDA, either in the acknowledge clock or in any later byte, until the next START or STOP. It also leaves the received-data register unchanged.
- R3: With control register 1 bit 0 clear (automatic mode), every byte written by the controller is acknowledged with SDA low. The byte is readable at register 2 and sets status bit 2, which is cleared by writing 1 to it.
- R4: With control bit 0 set (manual mode), the block holds SCL low after the eighth bit of a received byte, and status bit 6 shows the wait. A write to register 4 releases SCL and drives the acknowledge clock with SDA low when bit 0 = 0 (ACK) or released when bit 0 = 1 (NACK). After a NACK the block ignores the rest of the transfer.
- R5: A write to register 4 while the block is not waiting for a decision has no effect. A later wait still holds SCL low until a new decision is written.
- R6: In a read transfer the block sends the byte from register 3, most significant bit first. Its SDA drive changes only while SCL is low.
- R7: When a byte is due and register 3 holds no unsent byte, the block holds SCL low and sets status bit 3. It resumes as soon as the host writes register 3.
- R8: When the controller leaves SDA high in the acknowledge clock after a sent byte, the block sets status bit 4 (write 1 to clear), releases SDA and sends nothing more in that transfer.
- R9: A repeated START after any byte puts the block straight back into address reception. Status bits 0 and 1 follow the new address byte.
- R10: A STOP in any state returns the block to idle with both lines released. It clears status bits 0 and 1 and sets status bit 5, which stays set until the host writes 1 to it.
- R11: After reset both drive enables are low, the status register reads 0, the own address equals the parameter default and the control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sampled level of the SCL wire |
| sda_in | input | 1 | Sampled level of the SDA wire |
| scl_pull | output | 1 | Drive SCL low when 1 (clock stretching) |
| sda_pull | output | 1 | Drive SDA low when 1 |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register offset (0 own address, 1 control, 2 received data, 3 transmit data, 4 decision, 5 status) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr, combinational |

## Verification
A wrong bit counter or a wrong state shows up on SDA at the controller. The acknowledge lands in the wrong clock, or a transmitted byte arrives shifted, and the controller sees it within the same byte. A stretch that never ends freezes SCL, so the controller's next bit stalls at once. A stretch that is missing shows up when the acknowledge value is read before the host has decided. A stuck flag shows in the status register at the next host read, after a STOP or a repeated START that should have changed it.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int REG_W  = 3;

    // host register offsets
    localparam logic [REG_W-1:0] REG_OWN  = 3'd0;
    localparam logic [REG_W-1:0] REG_CTRL = 3'd1;
    localparam logic [REG_W-1:0] REG_RX   = 3'd2;
    localparam logic [REG_W-1:0] REG_TX   = 3'd3;
    localparam logic [REG_W-1:0] REG_DEC  = 3'd4;
    localparam logic [REG_W-1:0] REG_STAT = 3'd5;

    // status bit positions
    localparam int SB_HIT  = 0;
    localparam int SB_DIR  = 1;
    localparam int SB_RXF  = 2;
    localparam int SB_TXN  = 3;
    localparam int SB_NACK = 4;
    localparam int SB_STOP = 5;
    localparam int SB_WAIT = 6;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_END,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_END,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX_LOAD,
        ST_TX,
        ST_TX_ACK,
        ST_TX_ACK_END,
        ST_WAIT_STOP
    } tgt_state_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic addr_hit;
        logic dir_rd;
        logic rx_done;
        logic nack_rx;
        logic stop_seen;
        logic restart;
    } eng_evt_t;

    function automatic logic majority3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/i2c_tgt_filter.sv
module i2c_tgt_filter
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic line_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             win_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            win_q    <= '1;
            line_out <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], line_in};
            win_q    <= {win_q[1:0], sync_q[SYNC_STAGES-1]};
            line_out <= majority3(win_q);
        end
    end

endmodule

// File: rtl/i2c_tgt_events.sv
module i2c_tgt_events
    import i2c_tgt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl      = scl_f;
        ev.sda      = sda_f;
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & ~sda_f & sda_q;
        ev.stop     = scl_f & scl_q & sda_f & ~sda_q;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int SETUP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              manual_en,
    input  logic              tx_valid,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              dec_we,
    input  logic              dec_nack,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              tx_take,
    output logic [BYTE_W-1:0] rx_byte,
    output eng_evt_t          evt,
    output logic              hold_wait,
    output logic              tx_need
);

    localparam int RC_W  = $clog2(SETUP_CYC + 1);
    localparam int CNT_W = $clog2(BYTE_W);

    tgt_state_e        state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              read_q;
    logic              nack_q;
    logic              mack_q;
    logic              rel_pend;
    logic [RC_W-1:0]   rel_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            shreg    <= '0;
            cnt      <= '0;
            read_q   <= 1'b0;
            nack_q   <= 1'b0;
            mack_q   <= 1'b0;
            rel_pend <= 1'b0;
            rel_cnt  <= '0;
            sda_pull <= 1'b0;
            scl_pull <= 1'b0;
            tx_take  <= 1'b0;
            rx_byte  <= '0;
            evt      <= '0;
        end else begin
            evt     <= '0;
            tx_take <= 1'b0;
            // delayed SCL release gives SDA setup time before the clock rises
            if (rel_pend) begin
                if (rel_cnt == '0) begin
                    scl_pull <= 1'b0;
                    rel_pend <= 1'b0;
                end else begin
                    rel_cnt <= rel_cnt - 1'b1;
                end
            end
            if (ev.stop) begin
                state          <= ST_IDLE;
                sda_pull       <= 1'b0;
                scl_pull       <= 1'b0;
                rel_pend       <= 1'b0;
                evt.stop_seen  <= 1'b1;
            end else if (ev.start) begin
                state       <= ST_ADDR;
                cnt         <= '0;
                sda_pull    <= 1'b0;
                scl_pull    <= 1'b0;
                rel_pend    <= 1'b0;
                evt.restart <= 1'b1;
            end else begin
                case (state)
                    ST_ADDR, ST_RX: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], ev.sda};
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(BYTE_W - 1))
                                state <= (state == ST_ADDR) ? ST_ADDR_END : ST_RX_END;
                        end
                    end
                    ST_ADDR_END: begin
                        if (ev.scl_fall) begin
                            if (shreg[BYTE_W-1:1] == own_addr) begin
                                sda_pull     <= 1'b1;
                                read_q       <= shreg[0];
                                evt.addr_hit <= 1'b1;
                                evt.dir_rd   <= shreg[0];
                                state        <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            state    <= read_q ? ST_TX_LOAD : ST_RX;
                        end
                    end
                    ST_RX_END: begin
                        if (ev.scl_fall) begin
                            rx_byte     <= shreg;
                            evt.rx_done <= 1'b1;
                            if (manual_en) begin
                                scl_pull <= 1'b1;
                                state    <= ST_RX_HOLD;
                            end else begin
                                sda_pull <= 1'b1;
                                nack_q   <= 1'b0;
                                state    <= ST_RX_ACK;
                            end
                        end
                    end
                    ST_RX_HOLD: begin
                        if (dec_we) begin
                            sda_pull <= ~dec_nack;
                            nack_q   <= dec_nack;
                            rel_pend <= 1'b1;
                            rel_cnt  <= RC_W'(SETUP_CYC);
                            state    <= ST_RX_ACK;
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            sda_pull <= 1'b0;
                            cnt      <= '0;
                            state    <= nack_q ? ST_WAIT_STOP : ST_RX;
                        end
                    end
                    ST_TX_LOAD: begin
                        if (tx_valid) begin
                            shreg    <= tx_byte;
                            sda_pull <= ~tx_byte[BYTE_W-1];
                            tx_take  <= 1'b1;
                            cnt      <= '0;
                            rel_pend <= 1'b1;
                            rel_cnt  <= RC_W'(SETUP_CYC);
                            state    <= ST_TX;
                        end else begin
                            scl_pull <= 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                sda_pull <= 1'b0;
                                state    <= ST_TX_ACK;
                            end else begin
                                shreg    <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_pull <= ~shreg[BYTE_W-2];
                                cnt      <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                            state  <= ST_TX_ACK_END;
                        end
                    end
                    ST_TX_ACK_END: begin
                        if (ev.scl_fall) begin
                            if (mack_q) begin
                                state <= ST_TX_LOAD;
                            end else begin
                                evt.nack_rx <= 1'b1;
                                state       <= ST_WAIT_STOP;
                            end
                        end
                    end
                    ST_IDLE, ST_WAIT_STOP: ;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign hold_wait = (state == ST_RX_HOLD);
    assign tx_need   = (state == ST_TX_LOAD) && !tx_valid;

    AST_HOLD_KEEPS_SCL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RX_HOLD) |-> scl_pull);                                     // R4
    AST_MISS_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_STOP) |-> !sda_pull);                                  // R2
    AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(ev.scl) && ev.scl && !$past(ev.start) && !$past(ev.stop))
        |-> $stable(sda_pull));                                                  // R6
    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (state == ST_IDLE && !sda_pull && !scl_pull));                // R10
    AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> (state == ST_ADDR));                           // R9

endmodule

// File: rtl/i2c_tgt_defer.sv
module i2c_tgt_defer
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEFAULT_ADDR = 7'h50,
    parameter int         SYNC_STAGES  = 2,
    parameter int         SETUP_CYC    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       host_we,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;

    assign raw_lines = {sda_in, scl_in};

    for (genvar gi = 0; gi < NLINES; gi++) begin : g_filt
        i2c_tgt_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk      (clk),
            .rst      (rst),
            .line_in  (raw_lines[gi]),
            .line_out (filt_lines[gi])
        );
    end

    bus_ev_t ev;

    i2c_tgt_events u_events (
        .clk   (clk),
        .rst   (rst),
        .scl_f (filt_lines[0]),
        .sda_f (filt_lines[1]),
        .ev    (ev)
    );

    logic [ADDR_W-1:0] own_addr_q;
    logic              manual_q;
    logic [BYTE_W-1:0] tx_byte_q;
    logic              tx_valid_q;
    logic              hit_q, dir_q, rxf_q, nack_q, stop_q;
    logic              tx_take, hold_wait, tx_need;
    logic [BYTE_W-1:0] rx_byte;
    eng_evt_t          evt;

    wire wr_own  = host_we && (host_addr == REG_OWN);
    wire wr_ctrl = host_we && (host_addr == REG_CTRL);
    wire wr_tx   = host_we && (host_addr == REG_TX);
    wire wr_dec  = host_we && (host_addr == REG_DEC);
    wire wr_stat = host_we && (host_addr == REG_STAT);

    i2c_tgt_engine #(.SETUP_CYC(SETUP_CYC)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .own_addr  (own_addr_q),
        .manual_en (manual_q),
        .tx_valid  (tx_valid_q),
        .tx_byte   (tx_byte_q),
        .dec_we    (wr_dec),
        .dec_nack  (host_wdata[0]),
        .sda_pull  (sda_pull),
        .scl_pull  (scl_pull),
        .tx_take   (tx_take),
        .rx_byte   (rx_byte),
        .evt       (evt),
        .hold_wait (hold_wait),
        .tx_need   (tx_need)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            own_addr_q <= DEFAULT_ADDR;
            manual_q   <= 1'b0;
            tx_byte_q  <= '0;
            tx_valid_q <= 1'b0;
            hit_q      <= 1'b0;
            dir_q      <= 1'b0;
            rxf_q      <= 1'b0;
            nack_q     <= 1'b0;
            stop_q     <= 1'b0;
        end else begin
            if (wr_own)  own_addr_q <= host_wdata[ADDR_W-1:0];
            if (wr_ctrl) manual_q   <= host_wdata[0];
            if (tx_take) tx_valid_q <= 1'b0;
            if (wr_tx) begin
                tx_byte_q  <= host_wdata;
                tx_valid_q <= 1'b1;
            end
            if (evt.restart || evt.stop_seen) begin
                hit_q <= 1'b0;
                dir_q <= 1'b0;
            end
            if (evt.addr_hit) begin
                hit_q <= 1'b1;
                dir_q <= evt.dir_rd;
            end
            if (wr_stat && host_wdata[SB_RXF])  rxf_q  <= 1'b0;
            if (wr_stat && host_wdata[SB_NACK]) nack_q <= 1'b0;
            if (wr_stat && host_wdata[SB_STOP]) stop_q <= 1'b0;
            if (evt.rx_done)   rxf_q  <= 1'b1;
            if (evt.nack_rx)   nack_q <= 1'b1;
            if (evt.stop_seen) stop_q <= 1'b1;
        end
    end

    logic [7:0] status;

    always_comb begin
        status          = '0;
        status[SB_HIT]  = hit_q;
        status[SB_DIR]  = dir_q;
        status[SB_RXF]  = rxf_q;
        status[SB_TXN]  = tx_need;
        status[SB_NACK] = nack_q;
        status[SB_STOP] = stop_q;
        status[SB_WAIT] = hold_wait;
    end

    always_comb begin
        case (host_addr)
            REG_OWN:  host_rdata = {1'b0, own_addr_q};
            REG_CTRL: host_rdata = {7'b0, manual_q};
            REG_RX:   host_rdata = rx_byte;
            REG_TX:   host_rdata = tx_byte_q;
            REG_STAT: host_rdata = status;
            default:  host_rdata = '0;
        endcase
    end

    AST_STOP_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !(wr_stat && host_wdata[SB_STOP])) |=> stop_q);               // R10
    AST_TX_NEED_STRETCH: assert property (@(posedge clk) disable iff (rst)
        (tx_need && $past(tx_need)) |-> scl_pull);                               // R7

endmodule

// File: tb/test_i2c_tgt_defer.sv
`timescale 1ns/1ps
module test_i2c_tgt_defer;

    localparam int HALF = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl_low = 1'b0;
    logic       m_sda_low = 1'b0;
    logic       scl_pull, sda_pull;
    logic       scl_bus, sda_bus;
    logic       host_we = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;

    string exp_tag[$];
    int    exp_val[$];
    int    obs_val[$];

    logic in_miss = 1'b0;
    int   miss_drive = 0;
    int   sda_viol = 0;
    logic scl_prev = 1'b1;
    logic pull_prev = 1'b0;

    always #2.5 clk = ~clk;

    assign scl_bus = !(m_scl_low || scl_pull);
    assign sda_bus = !(m_sda_low || sda_pull);

    i2c_tgt_defer i_i2c_tgt_defer (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_bus),
        .sda_in     (sda_bus),
        .scl_pull   (scl_pull),
        .sda_pull   (sda_pull),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pairs expected items with bus observations
    always @(negedge clk) begin
        if (exp_val.size() > 0 && obs_val.size() > 0) begin
            check(exp_tag.pop_front(), obs_val.pop_front(), exp_val.pop_front());
        end
        if (!rst) begin
            if (in_miss && sda_pull) miss_drive++;
            if (scl_bus && scl_prev && (sda_pull != pull_prev)) sda_viol++;
        end
        scl_prev  <= scl_bus;
        pull_prev <= sda_pull;
    end

    task automatic expect_item(input string tag, input int v);
        exp_tag.push_back(tag);
        exp_val.push_back(v);
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (!scl_bus) @(negedge clk);
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_stat(input int bitidx);
        logic [7:0] d;
        for (int i = 0; i < 20000; i++) begin
            host_read(3'd5, d);
            if (d[bitidx]) break;
        end
    endtask

    task automatic bit_write(input logic b);
        nwait(10);
        m_sda_low = !b;
        nwait(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        nwait(HALF);
        m_scl_low = 1'b1;
    endtask

    task automatic bit_read(output logic b);
        nwait(10);
        m_sda_low = 1'b0;
        nwait(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        nwait(HALF / 2);
        b = sda_bus;
        nwait(HALF / 2);
        m_scl_low = 1'b1;
    endtask

    task automatic bus_start();
        nwait(10);
        m_sda_low = 1'b0;
        nwait(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        nwait(HALF);
        m_sda_low = 1'b1;
        nwait(HALF);
        m_scl_low = 1'b1;
    endtask

    task automatic bus_stop();
        nwait(10);
        m_sda_low = 1'b1;
        nwait(HALF);
        m_scl_low = 1'b0;
        wait_scl_high();
        nwait(HALF);
        m_sda_low = 1'b0;
        nwait(HALF);
    endtask

    task automatic master_write(input logic [7:0] byte_v);
        logic a;
        for (int i = 7; i >= 0; i--) bit_write(byte_v[i]);
        bit_read(a);
        obs_val.push_back(int'(a));
    endtask

    task automatic master_read(input logic ack_high);
        logic [7:0] v;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            bit_read(b);
            v[i] = b;
        end
        obs_val.push_back(int'(v));
        bit_write(ack_high);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        nwait(5);
        rst = 1'b0;
        nwait(2);

        // R11 reset state
        check("R11 scl_pull", int'(scl_pull), 0);
        check("R11 sda_pull", int'(sda_pull), 0);
        host_read(3'd5, d); check("R11 status", int'(d), 0);
        host_read(3'd0, d); check("R11 own address", int'(d), 'h50);
        host_read(3'd1, d); check("R11 control", int'(d), 0);

        host_write(3'd0, 8'h3C);
        host_write(3'd1, 8'h00);

        // R1 / R3 write transfer, automatic acknowledge
        bus_start();
        expect_item("R1 address ack", 0);
        master_write(8'h78);
        nwait(4);
        host_read(3'd5, d); check("R1 status match write", int'(d), 'h01);
        expect_item("R3 data ack", 0);
        master_write(8'hA5);
        nwait(4);
        host_read(3'd2, d); check("R3 rx byte", int'(d), 'hA5);
        host_read(3'd5, d); check("R3 rx flag", int'(d[2]), 1);
        expect_item("R3 second data ack", 0);
        master_write(8'h3C);
        bus_stop();
        nwait(10);
        host_read(3'd5, d); check("R10 status after stop", int'(d), 'h24);
        host_read(3'd2, d); check("R3 rx second byte", int'(d), 'h3C);
        host_write(3'd5, 8'h24);
        host_read(3'd5, d); check("R10 flags cleared", int'(d), 0);

        // R2 address mismatch
        in_miss = 1'b1;
        bus_start();
        expect_item("R2 address nack", 1);
        master_write(8'h44);
        expect_item("R2 data nack", 1);
        master_write(8'hFF);
        bus_stop();
        in_miss = 1'b0;
        check("R2 no SDA drive", miss_drive, 0);
        host_read(3'd2, d); check("R2 rx unchanged", int'(d), 'h3C);
        host_read(3'd5, d); check("R2 status only stop", int'(d), 'h20);
        host_write(3'd5, 8'h20);

        // R4 / R5 manual acknowledge
        host_write(3'd1, 8'h01);
        host_write(3'd4, 8'h00);   // no wait pending: must be ignored
        bus_start();
        expect_item("R4 address ack", 0);
        master_write(8'h78);
        expect_item("R4 manual ack", 0);
        fork
            master_write(8'h5A);
            begin
                wait_stat(6);
                nwait(200);
                check("R5 stale decision ignored, SCL held", int'(scl_pull), 1);
                check("R4 bus SCL low during wait", int'(scl_bus), 0);
                host_read(3'd5, d); check("R4 wait flag", int'(d[6]), 1);
                host_read(3'd2, d); check("R4 rx byte during wait", int'(d), 'h5A);
                host_write(3'd4, 8'h00);
            end
        join
        expect_item("R4 manual nack", 1);
        fork
            master_write(8'h11);
            begin
                wait_stat(6);
                host_write(3'd4, 8'h01);
            end
        join
        bus_stop();
        nwait(10);
        host_read(3'd2, d); check("R4 rx last byte", int'(d), 'h11);
        host_write(3'd5, 8'h34);
        host_write(3'd1, 8'h00);

        // R6 / R7 / R8 read transfer
        host_write(3'd3, 8'hC3);
        bus_start();
        expect_item("R1 read address ack", 0);
        master_write(8'h79);
        nwait(4);
        host_read(3'd5, d); check("R1 status match read", int'(d), 'h03);
        expect_item("R6 sent byte", 'hC3);
        master_read(1'b0);
        expect_item("R7 sent byte after stretch", 'h96);
        fork
            master_read(1'b1);
            begin
                wait_stat(3);
                nwait(100);
                check("R7 SCL stretched", int'(scl_pull), 1);
                host_write(3'd3, 8'h96);
            end
        join
        nwait(20);
        host_read(3'd5, d); check("R8 nack flag", int'(d), 'h13);
        check("R8 SDA released", int'(sda_pull), 0);

        // R9 repeated start into a write
        bus_start();
        expect_item("R9 address ack after restart", 0);
        master_write(8'h78);
        nwait(4);
        host_read(3'd5, d); check("R9 status after restart", int'(d), 'h11);
        expect_item("R9 data ack", 0);
        master_write(8'h42);
        nwait(4);
        host_read(3'd2, d); check("R9 rx byte", int'(d), 'h42);
        bus_stop();
        nwait(20);
        check("R10 lines released", int'(scl_pull | sda_pull), 0);
        check("R6 SDA steady while SCL high", sda_viol, 0);
        check("R1 scoreboard drained", exp_val.size() + obs_val.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule